// File: doc/BRIEF.md
# Predicate Flag and Literal Unit

This block holds the condition flags and the word-wide data latch of one instruction pump. Two flags, A and B, are written only by the program. The summary flag S always mirrors the top bit of the data latch. The zero flag Z is passed straight through from an external loop counter. Each instruction arrives as decoded fields together with an execute strobe. The block tests the instruction's two-bit predicate against the current flags, and the instruction changes state only when the strobe is high and the predicate holds.

Four kinds of operation change state:
- A flag update builds new A and B values. Each is the OR of whichever true or complemented flag terms an 8-bit mask selects.
- A high literal load writes the upper part of the latch.
- A low literal load writes the lower part of the latch.
- A whole-word literal load places a literal in one half and fills the other half with all zeros or all ones.

A capture operation loads the full input word into the latch. The predicate result is available at the same time as the instruction fields, so the surrounding control logic can use it.

Top module: `pfl_unit`

## Requirements
- R1: `pred_ok_o` is combinational in `pred_i` and the current flags: code 00 gives A, code 10 gives B, code 01 gives Z, and code 11 always gives 1.
- R2: A state change takes effect at the rising clock edge only when `exec_i` is 1 and `pred_ok_o` is 1. Otherwise the latch, A, B and S all keep their values.
- R3: `op_i` = 1 (flag update) loads A from `next_a_i` and B from `next_b_i`. Mask bit 7 selects A, bit 6 selects not A, bit 5 selects B, bit 4 selects not B, bit 3 selects S, bit 2 selects not S, bit 1 selects Z and bit 0 selects not Z. Both new values are computed from the flag values held before the edge.
- R4: A mask of all zeros writes 0. A mask that selects a flag together with its complement writes 1.
- R5: `flag_s_o` equals `data_o[DATA_W-1]` at all times, and a flag update never changes S. `flag_z_o` follows `zero_i`.
- R6: `op_i` = 2 (high load) writes `lit_i[17:0]` into `data_o[36:19]` and leaves `data_o[18:0]` unchanged. S takes the value of `lit_i[17]`.
- R7: `op_i` = 3 (low load) writes `lit_i[18:0]` into `data_o[18:0]`. It leaves `data_o[36:19]` and S unchanged.
- R8: `op_i` = 4 (whole-word load) selects its layout with `sel_i`:
  - 00: `lit_i[17:0]` in the high part, zeros in the low part.
  - 01: `lit_i[17:0]` in the high part, ones in the low part.
  - 10: `lit_i[18:0]` in the low part, zeros in the high part.
  - 11: `lit_i[18:0]` in the low part, ones in the high part.
- R9: `op_i` = 5 (capture) loads all of `data_i` into the latch. `op_i` values 0, 6 and 7 change nothing.
- R10: While `rst_ni` is low, the latch, A, B and S are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for the presented instruction |
| op_i | input | 3 | Operation code |
| pred_i | input | 2 | Predicate code |
| next_a_i | input | 8 | Term mask for the new A |
| next_b_i | input | 8 | Term mask for the new B |
| lit_i | input | 19 | Literal field |
| sel_i | input | 2 | Layout select for the whole-word load |
| data_i | input | 37 | Word to capture |
| zero_i | input | 1 | Loop counter is zero |
| pred_ok_o | output | 1 | Predicate holds |
| flag_a_o | output | 1 | Flag A |
| flag_b_o | output | 1 | Flag B |
| flag_s_o | output | 1 | Summary flag |
| flag_z_o | output | 1 | Zero flag |
| data_o | output | 37 | Data latch |

## Verification
Random operations run with random masks, literals, select codes, predicate codes and Z values. Together they cover every term combination and every fill polarity, and show whether a term is selected or inverted wrongly.

Directed cases cover the following:
- An empty mask and a mask that selects a flag with its complement, which tells the OR reduction apart from the fixed results.
- A mask that swaps A and B, which shows whether both updates read the flags held before the edge.
- A high and a low load of all ones over an opposite background, which show whether either load spills into the other half.
- A failing predicate and a low strobe, which confirm that the state is held.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int unsigned MASK_W = 8;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_FLAGS = 3'd1,
    OP_LIT_HI = 3'd2,
    OP_LIT_LO = 3'd3,
    OP_LIT_WD = 3'd4,
    OP_CAP   = 3'd5
  } op_e;

  localparam logic [1:0] PRED_A    = 2'b00;
  localparam logic [1:0] PRED_Z    = 2'b01;
  localparam logic [1:0] PRED_B    = 2'b10;
  localparam logic [1:0] PRED_TRUE = 2'b11;
endpackage

// File: rtl/pfl_pred.sv
module pfl_pred
  import pfl_pkg::*;
(
  input  logic [1:0] pred_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       z_i,
  output logic       ok_o
);
  always_comb begin
    unique case (pred_i)
      PRED_A:  ok_o = a_i;
      PRED_B:  ok_o = b_i;
      PRED_Z:  ok_o = z_i;
      default: ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pfl_flag_term.sv
module pfl_flag_term
  import pfl_pkg::*;
(
  input  logic [MASK_W-1:0] mask_i,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              s_i,
  input  logic              z_i,
  output logic              val_o
);
  logic [MASK_W-1:0] terms;

  // msb first: A, ~A, B, ~B, S, ~S, Z, ~Z
  assign terms = {a_i, ~a_i, b_i, ~b_i, s_i, ~s_i, z_i, ~z_i};
  assign val_o = |(mask_i & terms);
endmodule

// File: rtl/pfl_lit_mux.sv
module pfl_lit_mux
  import pfl_pkg::*;
#(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned HI_W   = 18,
  localparam int unsigned LO_W  = DATA_W - HI_W
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [LO_W-1:0]   lit_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] nxt_o,
  output logic              ld_o
);
  logic [DATA_W-1:0] word_v;

  // whole-word load: sel[1] picks the half, sel[0] is the fill value
  always_comb begin
    if (!sel_i[1]) word_v = {lit_i[HI_W-1:0], {LO_W{sel_i[0]}}};
    else           word_v = {{HI_W{sel_i[0]}}, lit_i};
  end

  always_comb begin
    nxt_o = cur_i;
    ld_o  = 1'b1;
    unique case (op_i)
      OP_LIT_HI: nxt_o = {lit_i[HI_W-1:0], cur_i[LO_W-1:0]};
      OP_LIT_LO: nxt_o = {cur_i[DATA_W-1:LO_W], lit_i};
      OP_LIT_WD: nxt_o = word_v;
      OP_CAP:    nxt_o = data_i;
      default:   ld_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfl_unit.sv
module pfl_unit
  import pfl_pkg::*;
#(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned HI_W   = 18,
  localparam int unsigned LO_W  = DATA_W - HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        pred_i,
  input  logic [MASK_W-1:0] next_a_i,
  input  logic [MASK_W-1:0] next_b_i,
  input  logic [LO_W-1:0]   lit_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              zero_i,
  output logic              pred_ok_o,
  output logic              flag_a_o,
  output logic              flag_b_o,
  output logic              flag_s_o,
  output logic              flag_z_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned N_PROG = 2;

  logic [DATA_W-1:0] d_q, d_nxt;
  logic              a_q, b_q, s_q;
  logic              ld;
  logic              fire;
  logic [MASK_W-1:0] masks [N_PROG];
  logic [N_PROG-1:0] flag_nxt;

  assign masks[0] = next_a_i;
  assign masks[1] = next_b_i;

  pfl_pred i_pred (
    .pred_i (pred_i),
    .a_i    (a_q),
    .b_i    (b_q),
    .z_i    (zero_i),
    .ok_o   (pred_ok_o)
  );

  for (genvar g = 0; g < N_PROG; g++) begin : g_flag
    pfl_flag_term i_term (
      .mask_i (masks[g]),
      .a_i    (a_q),
      .b_i    (b_q),
      .s_i    (s_q),
      .z_i    (zero_i),
      .val_o  (flag_nxt[g])
    );
  end

  pfl_lit_mux #(.DATA_W(DATA_W), .HI_W(HI_W)) i_mux (
    .op_i   (op_i),
    .lit_i  (lit_i),
    .sel_i  (sel_i),
    .data_i (data_i),
    .cur_i  (d_q),
    .nxt_o  (d_nxt),
    .ld_o   (ld)
  );

  assign fire = exec_i & pred_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      s_q <= 1'b0;
    end else if (fire && ld) begin
      d_q <= d_nxt;
      s_q <= d_nxt[DATA_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else if (fire && op_i == OP_FLAGS) begin
      a_q <= flag_nxt[0];
      b_q <= flag_nxt[1];
    end
  end

  assign flag_a_o = a_q;
  assign flag_b_o = b_q;
  assign flag_s_o = s_q;
  assign flag_z_o = zero_i;
  assign data_o   = d_q;
endmodule

// File: rtl/pfl_unit_chk.sv
module pfl_unit_chk
  import pfl_pkg::*;
#(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned HI_W   = 18,
  localparam int unsigned LO_W  = DATA_W - HI_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [OP_W-1:0]   op_i,
  input logic [1:0]        pred_i,
  input logic [LO_W-1:0]   lit_i,
  input logic [DATA_W-1:0] data_i,
  input logic              pred_ok_o,
  input logic              flag_a_o,
  input logic              flag_b_o,
  input logic              flag_s_o,
  input logic [DATA_W-1:0] data_o
);
  AST_PRED_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_i == PRED_TRUE |-> pred_ok_o); // R1

  AST_HOLD_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_i || !pred_ok_o) |=> ($stable(data_o) && $stable(flag_a_o)
                                 && $stable(flag_b_o) && $stable(flag_s_o))); // R2

  AST_S_MIRRORS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_s_o == data_o[DATA_W-1]); // R5

  AST_FLAGS_KEEP_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && pred_ok_o && op_i == OP_FLAGS) |=> $stable(flag_s_o)); // R5

  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && pred_ok_o && op_i == OP_LIT_HI) |=>
      (data_o[DATA_W-1:LO_W] == $past(lit_i[HI_W-1:0])
       && data_o[LO_W-1:0] == $past(data_o[LO_W-1:0]))); // R6

  AST_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && pred_ok_o && op_i == OP_LIT_LO) |=>
      (data_o[LO_W-1:0] == $past(lit_i)
       && data_o[DATA_W-1:LO_W] == $past(data_o[DATA_W-1:LO_W]))); // R7

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && pred_ok_o && op_i == OP_CAP) |=> data_o == $past(data_i)); // R9
endmodule

bind pfl_unit pfl_unit_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) i_pfl_unit_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exec_i    (exec_i),
  .op_i      (op_i),
  .pred_i    (pred_i),
  .lit_i     (lit_i),
  .data_i    (data_i),
  .pred_ok_o (pred_ok_o),
  .flag_a_o  (flag_a_o),
  .flag_b_o  (flag_b_o),
  .flag_s_o  (flag_s_o),
  .data_o    (data_o)
);

// File: tb/test_pfl_unit.sv
`timescale 1ns/1ps
module test_pfl_unit;
  localparam int DW = 37;
  localparam int HW = 18;
  localparam int LW = DW - HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exec = 1'b0;
  logic [2:0]    op = '0;
  logic [1:0]    pred = 2'b11;
  logic [7:0]    ma = '0, mb = '0;
  logic [LW-1:0] lit = '0;
  logic [1:0]    sel = '0;
  logic [DW-1:0] din = '0;
  logic          zin = 1'b0;
  logic          pok, fa, fb, fs, fz;
  logic [DW-1:0] dout;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] m_d = '0;
  logic m_a = 1'b0, m_b = 1'b0, m_s = 1'b0;

  always #10 clk = ~clk;

  pfl_unit i_pfl_unit (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op), .pred_i(pred),
    .next_a_i(ma), .next_b_i(mb), .lit_i(lit), .sel_i(sel), .data_i(din),
    .zero_i(zin), .pred_ok_o(pok), .flag_a_o(fa), .flag_b_o(fb),
    .flag_s_o(fs), .flag_z_o(fz), .data_o(dout)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic f_pred(logic [1:0] p, logic a, logic b, logic z);
    case (p)
      2'b00: return a;
      2'b10: return b;
      2'b01: return z;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic f_mask(logic [7:0] m, logic a, logic b, logic s, logic z);
    logic [7:0] t;
    t = {a, ~a, b, ~b, s, ~s, z, ~z};
    return |(m & t);
  endfunction

  function automatic string f_req(logic [2:0] o);
    case (o)
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R2";
    endcase
  endfunction

  // drive at negedge, check predicate, clock once, check state at next negedge
  task automatic apply(input logic e, input logic [2:0] o, input logic [1:0] p,
                       input logic [7:0] xa, input logic [7:0] xb,
                       input logic [LW-1:0] l, input logic [1:0] s,
                       input logic [DW-1:0] d, input logic z, input string req);
    logic ok, na, nb;
    exec = e; op = o; pred = p; ma = xa; mb = xb; lit = l; sel = s; din = d; zin = z;
    #2;
    ok = f_pred(p, m_a, m_b, z);
    chk("R1", {63'd0, pok}, {63'd0, ok});
    chk("R5", {63'd0, fz}, {63'd0, z});
    na = f_mask(xa, m_a, m_b, m_s, z);
    nb = f_mask(xb, m_a, m_b, m_s, z);
    if (e && ok) begin
      case (o)
        3'd1: begin m_a = na; m_b = nb; end
        3'd2: m_d = {l[HW-1:0], m_d[LW-1:0]};
        3'd3: m_d = {m_d[DW-1:LW], l};
        3'd4: m_d = s[1] ? {{HW{s[0]}}, l} : {l[HW-1:0], {LW{s[0]}}};
        3'd5: m_d = d;
        default: ;
      endcase
      m_s = m_d[DW-1];
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, {27'd0, dout}, {27'd0, m_d});
    chk(req, {61'd0, fa, fb, fs}, {61'd0, m_a, m_b, m_s});
    chk("R5", {63'd0, fs}, {63'd0, dout[DW-1]});
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10", {27'd0, dout}, 64'd0);
    chk("R10", {61'd0, fa, fb, fs}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: all four layouts, each preceded by a background that exposes the fill
    apply(1, 3'd4, 2'b11, 0, 0, 19'h2ABCD, 2'b00, 0, 0, "R8");
    apply(1, 3'd4, 2'b11, 0, 0, 19'h2ABCD, 2'b01, 0, 0, "R8");
    apply(1, 3'd4, 2'b11, 0, 0, 19'h4ABCD, 2'b10, 0, 0, "R8");
    apply(1, 3'd4, 2'b11, 0, 0, 19'h0ABCD, 2'b11, 0, 0, "R8");
    // R6 / R7: ones over a zero background must not spill across the halves
    apply(1, 3'd5, 2'b11, 0, 0, 0, 0, '0, 0, "R9");
    apply(1, 3'd2, 2'b11, 0, 0, '1, 0, 0, 0, "R6");
    chk("R6", {63'd0, fs}, 64'd1);
    apply(1, 3'd5, 2'b11, 0, 0, 0, 0, '0, 0, "R9");
    apply(1, 3'd3, 2'b11, 0, 0, '1, 0, 0, 0, "R7");
    chk("R7", {63'd0, fs}, 64'd0);
    // R4: set A with A|~A, clear B with an empty mask
    apply(1, 3'd1, 2'b11, 8'hC0, 8'h00, 0, 0, 0, 0, "R4");
    chk("R4", {62'd0, fa, fb}, 64'd2);
    apply(1, 3'd1, 2'b11, 8'h00, 8'h03, 0, 0, 0, 1, "R4");
    chk("R4", {62'd0, fa, fb}, 64'd1);
    // R3: swap A and B; both read the old values
    apply(1, 3'd1, 2'b11, 8'h20, 8'h80, 0, 0, 0, 0, "R3");
    chk("R3", {62'd0, fa, fb}, 64'd2);
    // R5: capture with top bit set, then a flag op leaves S alone
    apply(1, 3'd5, 2'b11, 0, 0, 0, 0, {1'b1, 36'h123456789}, 0, "R9");
    apply(1, 3'd1, 2'b11, 8'h08, 8'h04, 0, 0, 0, 0, "R5");
    chk("R5", {62'd0, fa, fs}, 64'd3);
    // R2: failing predicate (B now 0), idle strobe, unused op codes
    apply(1, 3'd5, 2'b10, 0, 0, 0, 0, 37'h0_5555_5555, 0, "R2");
    apply(0, 3'd5, 2'b11, 0, 0, 0, 0, 37'h0_5555_5555, 0, "R2");
    apply(1, 3'd6, 2'b11, 8'hFF, 8'hFF, '1, 0, '1, 0, "R9");
    apply(1, 3'd0, 2'b11, 0, 0, '1, 0, '1, 0, "R9");
    apply(1, 3'd1, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0, "R2");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      apply(1'($urandom_range(0, 7) != 0), o, 2'($urandom), 8'($urandom), 8'($urandom),
            19'($urandom), 2'($urandom), {5'($urandom), 32'($urandom)},
            1'($urandom), f_req(o));
    end

    exec = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule